// File: doc/BRIEF.md
# Masked SIMD High-Half Interleave Unit

This unit is a registered vector execution stage with a 512-bit datapath. It takes two source vectors of opaque 32-bit words. Inside every 128-bit lane it builds the result from the upper two words of the first source and the upper two words of the second source, alternating between them. The words are never interpreted as numbers.

A 2-bit length code sets how many lanes take part. An optional broadcast copies word 0 of the second source into every word position before the interleave. A per-word write mask, when enabled, chooses for each active word between the computed value and either the old destination word (merge) or zero. In the normal modes the words above the active length are cleared. A legacy mode works on one lane only and passes the old destination through above bit 127.

The caller presents the operands, the old destination and the mode bits with `valid_i`. The result follows one clock later with `valid_o`.

Top module: `hi_ilv_unit`

## Requirements
- R1: Word k sits at bits 32k+31:32k. Within each 128-bit lane, result words 0, 1, 2 and 3 are first-source word 2, second-source word 2, first-source word 3 and second-source word 3 of that same lane.
- R2: `vlen_i` sets the active lanes: code 0 gives 1 lane (4 words), code 1 gives 2 lanes (8 words), and codes 2 and 3 give 4 lanes (16 words).
- R3: When `bcast_i` is 1 outside legacy mode, every second-source word is taken as second-source word 0 (bits 31:0) before the interleave.
- R4: An active word j takes the computed value when `mask_en_i` is 0 or `mask_i[j]` is 1.
- R5: An active word j with `mask_en_i`=1, `mask_i[j]`=0 and `zero_i`=0 takes old-destination word j.
- R6: An active word j with `mask_en_i`=1, `mask_i[j]`=0 and `zero_i`=1 is zero.
- R7: Outside legacy mode, every word at or above the active word count is zero.
- R8: When `legacy_i`=1, one lane is active, mask and broadcast are treated as off whatever their inputs, and `dst_o[511:128]` equals `old_dst_i[511:128]`.
- R9: Inputs are captured on the rising clock edge where `valid_i`=1, and `valid_o` is high for exactly the next cycle. When `valid_i`=0, `dst_o` holds its value. Reset clears `valid_o` and `dst_o`.
- R10: Mask bits whose word index is at or above the active word count have no effect on `dst_o`.
- R11: Words 0 and 1 of each lane of either source have no effect on `dst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid, capture this cycle |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| old_dst_i | input | 512 | Previous destination, used for merging and legacy pass-through |
| mask_i | input | 16 | Per-word write mask |
| vlen_i | input | 2 | Length code: 0=128, 1=256, 2 and 3=512 bits |
| mask_en_i | input | 1 | Enable the write mask |
| zero_i | input | 1 | 1 zeroes masked-off words, 0 merges the old word |
| bcast_i | input | 1 | Broadcast second-source word 0 |
| legacy_i | input | 1 | Legacy one-lane mode, overrides the other mode bits |
| valid_o | output | 1 | Result valid |
| dst_o | output | 512 | Result vector |

## Verification
The bench aims at the places where the lane and word selection is easy to get wrong.

An interleave that swaps the two sources, or that reads the lower half of a lane, shows up as wrong words once the low-half inputs are changed on their own. A broadcast that reads the wrong word, or that reaches the first source, corrupts upper lanes that carry distinct data. Length code 3 and mask bits set above the active count catch a tail decoder that wraps or leaks.

Legacy operations with the mask, zeroing and broadcast bits all set expose a design that lets those bits through. The same operations show whether it clears the upper 384 bits instead of passing them through.

// File: rtl/hi_ilv_pkg.sv
package hi_ilv_pkg;
  localparam int unsigned LANE_W   = 128;
  localparam int unsigned ELEM_W_D = 32;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_RSV = 2'd3
  } vlen_e;
endpackage

// File: rtl/hi_ilv_bcast.sv
module hi_ilv_bcast #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned ELEM_W = 32
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic             en_i,
  output logic [VEC_W-1:0] src_o
);
  localparam int unsigned N_ELEM = VEC_W / ELEM_W;

  for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
    assign src_o[j*ELEM_W +: ELEM_W] = en_i ? src_i[ELEM_W-1:0] : src_i[j*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/hi_ilv_lanes.sv
module hi_ilv_lanes
  import hi_ilv_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned ELEM_W = 32
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] ilv_o
);
  localparam int unsigned N_LANE    = VEC_W / LANE_W;
  localparam int unsigned LANE_ELEM = LANE_W / ELEM_W;
  localparam int unsigned HALF      = LANE_ELEM / 2;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      // upper half of lane, alternating first/second source
      assign ilv_o[l*LANE_W + (2*k)*ELEM_W   +: ELEM_W] = a_i[l*LANE_W + (HALF+k)*ELEM_W +: ELEM_W];
      assign ilv_o[l*LANE_W + (2*k+1)*ELEM_W +: ELEM_W] = b_i[l*LANE_W + (HALF+k)*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/hi_ilv_wmask.sv
module hi_ilv_wmask
  import hi_ilv_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned VL_W   = 2
) (
  input  logic [VEC_W-1:0]        ilv_i,
  input  logic [VEC_W-1:0]        old_i,
  input  logic [VEC_W/ELEM_W-1:0] mask_i,
  input  logic [VL_W-1:0]         vlen_i,
  input  logic                    mask_en_i,
  input  logic                    zero_i,
  input  logic                    legacy_i,
  output logic [VEC_W-1:0]        res_o
);
  localparam int unsigned N_ELEM    = VEC_W / ELEM_W;
  localparam int unsigned N_LANE    = VEC_W / LANE_W;
  localparam int unsigned LANE_ELEM = LANE_W / ELEM_W;
  localparam int unsigned LOG_LANE  = $clog2(N_LANE);
  localparam int unsigned ALW       = LOG_LANE + 1;

  logic [ALW-1:0] act_lanes;
  logic           men;

  always_comb begin
    if (legacy_i)                     act_lanes = ALW'(1);
    else if (32'(vlen_i) >= LOG_LANE) act_lanes = ALW'(N_LANE);
    else                              act_lanes = ALW'(1) << vlen_i;
  end

  assign men = mask_en_i & ~legacy_i;

  for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
    localparam int unsigned LANE_IDX = j / LANE_ELEM;
    logic act;
    assign act = (ALW'(LANE_IDX) < act_lanes);

    always_comb begin
      if (act) begin
        if (!men || mask_i[j])  res_o[j*ELEM_W +: ELEM_W] = ilv_i[j*ELEM_W +: ELEM_W];
        else if (zero_i)        res_o[j*ELEM_W +: ELEM_W] = '0;
        else                    res_o[j*ELEM_W +: ELEM_W] = old_i[j*ELEM_W +: ELEM_W];
      end else begin
        res_o[j*ELEM_W +: ELEM_W] = legacy_i ? old_i[j*ELEM_W +: ELEM_W] : '0;
      end
    end
  end
endmodule

// File: rtl/hi_ilv_unit.sv
module hi_ilv_unit
  import hi_ilv_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned ELEM_W = ELEM_W_D,
  parameter int unsigned VL_W   = 2,
  localparam int unsigned N_ELEM = VEC_W / ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [VEC_W-1:0]  old_dst_i,
  input  logic [N_ELEM-1:0] mask_i,
  input  logic [VL_W-1:0]   vlen_i,
  input  logic              mask_en_i,
  input  logic              zero_i,
  input  logic              bcast_i,
  input  logic              legacy_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  dst_o
);
  logic [VEC_W-1:0] b_eff, ilv, res;

  hi_ilv_bcast #(.VEC_W(VEC_W), .ELEM_W(ELEM_W)) u_bcast (
    .src_i (src_b_i),
    .en_i  (bcast_i & ~legacy_i),
    .src_o (b_eff)
  );

  hi_ilv_lanes #(.VEC_W(VEC_W), .ELEM_W(ELEM_W)) u_lanes (
    .a_i   (src_a_i),
    .b_i   (b_eff),
    .ilv_o (ilv)
  );

  hi_ilv_wmask #(.VEC_W(VEC_W), .ELEM_W(ELEM_W), .VL_W(VL_W)) u_wmask (
    .ilv_i     (ilv),
    .old_i     (old_dst_i),
    .mask_i    (mask_i),
    .vlen_i    (vlen_i),
    .mask_en_i (mask_en_i),
    .zero_i    (zero_i),
    .legacy_i  (legacy_i),
    .res_o     (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dst_o <= res;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o));

  // R7
  tail_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legacy_i && vlen_i == VL_W'(0)) |=> (dst_o[VEC_W-1:LANE_W] == '0));

  // R8
  legacy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legacy_i) |=> (dst_o[VEC_W-1:LANE_W] == $past(old_dst_i[VEC_W-1:LANE_W])));

  // R6
  zero_word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legacy_i && mask_en_i && zero_i && !mask_i[0]) |=> (dst_o[ELEM_W-1:0] == '0));

  // R5
  merge_word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legacy_i && mask_en_i && !zero_i && !mask_i[0])
      |=> (dst_o[ELEM_W-1:0] == $past(old_dst_i[ELEM_W-1:0])));
endmodule

// File: tb/hi_ilv_unit_tb.sv
module hi_ilv_unit_tb;
  localparam int CYC = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [511:0] src_a_i = '0, src_b_i = '0, old_dst_i = '0;
  logic [15:0]  mask_i = '0;
  logic [1:0]   vlen_i = '0;
  logic         mask_en_i = 0, zero_i = 0, bcast_i = 0, legacy_i = 0;
  logic         valid_o;
  logic [511:0] dst_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [511:0] exp_d = '0;
  logic         exp_v = 1'b0;

  always #(CYC/2) clk_i = ~clk_i;

  hi_ilv_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .src_a_i, .src_b_i, .old_dst_i, .mask_i,
    .vlen_i, .mask_en_i, .zero_i, .bcast_i, .legacy_i, .valid_o, .dst_o
  );

  function automatic logic [511:0] model();
    logic [511:0] r;
    int words;
    r = '0;
    if (legacy_i)             words = 4;
    else if (vlen_i == 2'd0)  words = 4;
    else if (vlen_i == 2'd1)  words = 8;
    else                      words = 16;
    for (int j = 0; j < 16; j++) begin
      int src_idx;
      logic [31:0] calc, av, bv;
      src_idx = (j / 4) * 4 + 2 + (j % 4) / 2;
      av = src_a_i[src_idx*32 +: 32];
      bv = (bcast_i && !legacy_i) ? src_b_i[31:0] : src_b_i[src_idx*32 +: 32];
      calc = (j % 2 == 0) ? av : bv;
      if (j >= words)
        r[j*32 +: 32] = legacy_i ? old_dst_i[j*32 +: 32] : 32'h0;
      else if (legacy_i || !mask_en_i || mask_i[j])
        r[j*32 +: 32] = calc;
      else
        r[j*32 +: 32] = zero_i ? 32'h0 : old_dst_i[j*32 +: 32];
    end
    return r;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (valid_o !== exp_v || dst_o !== exp_d) begin
      n_bad++;
      $display("FAIL %s valid actual=%0b expected=%0b dst actual=%h expected=%h",
               tag, valid_o, exp_v, dst_o, exp_d);
    end
  endtask

  // apply current inputs for one cycle, then check result
  task automatic cyc(string tag);
    if (valid_i) exp_d = model();
    exp_v = valid_i;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic rnd_ops();
    for (int i = 0; i < 16; i++) begin
      src_a_i[i*32 +: 32]   = $urandom;
      src_b_i[i*32 +: 32]   = $urandom;
      old_dst_i[i*32 +: 32] = $urandom;
    end
  endtask

  task automatic mode(input logic [1:0] vl, input logic men, input logic zr,
                      input logic bc, input logic lg, input logic [15:0] m);
    vlen_i = vl; mask_en_i = men; zero_i = zr; bcast_i = bc; legacy_i = lg; mask_i = m;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 16; i++) begin
      src_a_i[i*32 +: 32]   = 32'hA000_0000 + i;
      src_b_i[i*32 +: 32]   = 32'hB000_0000 + i;
      old_dst_i[i*32 +: 32] = 32'hC000_0000 + i;
    end
    valid_i = 1;
    mode(2'd2, 0, 0, 0, 0, 16'h0);  cyc("R1 full interleave");
    mode(2'd0, 0, 0, 0, 0, 16'h0);  cyc("R2 len128");
    mode(2'd1, 0, 0, 0, 0, 16'h0);  cyc("R2 len256");
    mode(2'd3, 0, 0, 0, 0, 16'h0);  cyc("R2 reserved code");
    mode(2'd2, 0, 0, 1, 0, 16'h0);  cyc("R3 broadcast");
    mode(2'd2, 1, 0, 0, 0, 16'hFFFF); cyc("R4 mask all set");
    mode(2'd2, 1, 0, 0, 0, 16'hA5C3); cyc("R5 merge");
    mode(2'd2, 1, 1, 0, 0, 16'h3C5A); cyc("R6 zeroing");
    mode(2'd0, 1, 0, 0, 0, 16'h0005); cyc("R7 tail len128 merge");
    mode(2'd1, 1, 1, 1, 0, 16'h00F0); cyc("R7 tail len256 zero");
    mode(2'd2, 1, 1, 1, 1, 16'h0000); cyc("R8 legacy overrides");
    mode(2'd1, 0, 0, 1, 1, 16'hFFFF); cyc("R8 legacy keep upper");
    mode(2'd0, 1, 1, 0, 0, 16'hFFF0); cyc("R10 high mask bits len128");
    mode(2'd1, 1, 0, 0, 0, 16'hFF00); cyc("R10 high mask bits len256");
    for (int l = 0; l < 4; l++) begin
      src_a_i[l*128 +: 64] = 64'h1111_2222_3333_4444 ^ l;
      src_b_i[l*128 +: 64] = 64'h5555_6666_7777_8888 ^ l;
    end
    mode(2'd2, 0, 0, 0, 0, 16'h0);  cyc("R11 low words ignored");

    valid_i = 0;
    rnd_ops();
    mode(2'd2, 1, 1, 1, 0, 16'h1234);
    cyc("R9 hold idle");
    cyc("R9 hold idle 2");
    valid_i = 1; cyc("R9 single pulse");
    valid_i = 0; cyc("R9 valid drops");

    for (int n = 0; n < 400; n++) begin
      rnd_ops();
      valid_i = ($urandom % 4) != 0;
      mode(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 5) == 0, 16'($urandom));
      cyc("R1 R4 random");
    end

    valid_i = 0;
    rst_ni = 0;
    #1;
    exp_v = 0; exp_d = '0;
    check("R9 async reset");
    done = 1;
    summary();
    $finish;
  end
endmodule